// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block cleans up one asynchronous serial input, such as receive data or an externally supplied serial clock, before receiver logic in the system clock domain uses it. It first resynchronises the raw level through a short flip-flop chain. It then passes the level through a spike suppressor, which drops any level change that does not persist long enough. A separate instance is placed on each filtered signal. The same 3-bit setting format applies to every instance.

The setting selects both the synchroniser depth and the suppression length:

| Setting | Synchroniser depth | Suppression N |
| --- | --- | --- |
| 000 | two stages | none |
| 001 | three stages | none |
| 010 to 111 | three stages | N = setting − 1, so 1 to 6 clocks |

When suppression is N, a new synchronised level must be seen on N+1 consecutive clocks before the output takes it.

The suppressor is a two-state machine:
- `ST_IDLE`: the synchronised level equals the output.
- `ST_PEND`: a differing level is being timed.

It has four transitions:
- `IDLE->IDLE (follow)`: a mismatch is seen while N = 0, so the output flips at once.
- `IDLE->PEND (start)`: a mismatch is seen while N > 0, so timing begins and the count is 1.
- `PEND->IDLE (drop)`: the level returns to the output value, so the count is cleared and the output is unchanged.
- `PEND->IDLE (accept)`: the count reaches N while the mismatch persists, so the output flips.

Top module: `glitch_filter`

## Requirements
- R1: While reset is asserted and after it is released, `filt_out` is 1 (idle high) and the suppressor is in `ST_IDLE` with a count of 0.
- R2: Setting 000 uses two synchroniser stages and no suppression. A raw change driven before clock edge 1 appears on `filt_out` at edge 3, and not before.
- R3: Setting 001 uses three synchroniser stages and no suppression. A raw change appears on `filt_out` at edge 4.
- R4: Settings 010 to 111 use three stages and suppression N = setting − 1. A lasting raw change appears on `filt_out` at edge setting + 3.
- R5: With suppression N, a raw pulse lasting W clocks is removed completely when W ≤ N. A pulse with W ≥ N+1 is passed with a width of exactly W clocks.
- R6: The qualification count restarts whenever the synchronised level returns to the output value. With N = 3, low runs of 2, 2 and 3 clocks separated by single high clocks produce no output change.
- R7: Changing the setting while the input is steady, or while a change is being timed, never makes `filt_out` toggle more than once per real input change. The output only moves to the current synchronised level.
- R8: Filtering is symmetric. High pulses on a low baseline are suppressed or passed by the same rule as low pulses on a high baseline.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| filt_sel | input | 3 | Setting for synchroniser depth and suppression length |
| raw_in | input | 1 | Asynchronous input to be filtered |
| filt_out | output | 1 | Filtered, synchronised level (idle high) |

## Verification
On every cycle, the embedded assertions check the suppressor's own rules:
- the output only moves toward a differing synchronised level;
- a matching level clears the count;
- with zero suppression, the output follows the synchroniser one cycle later;
- the count never exceeds the largest suppression length.

End-to-end behaviour needs the bench's directed scenarios. These cover the exact edge on which the output changes for each setting, the widths at which pulses are dropped or kept, the count restarting on broken runs, the absence of extra edges when the setting changes, and symmetry between high and low pulses.

// File: rtl/gf_pkg.sv
package gf_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } gf_state_e;

endpackage

// File: rtl/gf_decode.sv
module gf_decode #(
    parameter int CODE_W = 3,
    localparam int MAX_SUP = (1 << CODE_W) - 2,
    localparam int CNT_W = $clog2(MAX_SUP + 1)
) (
    input  logic [CODE_W-1:0] code,
    output logic              deep,
    output logic [CNT_W-1:0]  sup_len
);

    always_comb begin
        deep    = (code != '0);
        sup_len = '0;
        if (code > CODE_W'(1)) begin
            sup_len = CNT_W'(code - CODE_W'(1));
        end
    end

endmodule

// File: rtl/gf_sync.sv
module gf_sync #(
    parameter int   STAGES   = 3,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic deep,
    input  logic raw_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{IDLE_LVL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], raw_in};
        end
    end

    always_comb begin
        sync_out = deep ? chain_q[STAGES-1] : chain_q[STAGES-2];
    end

endmodule

// File: rtl/gf_suppress.sv
module gf_suppress
    import gf_pkg::*;
#(
    parameter int   CNT_W    = 3,
    parameter int   MAX_SUP  = 6,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] sup_len,
    input  logic             sync_in,
    output logic             level_out
);

    gf_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             level_q;
    logic             take;
    logic             mismatch;

    assign mismatch  = (sync_in != level_q);
    assign level_out = level_q;

    // Next-state and count logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (mismatch) begin
                    if (sup_len == '0) begin
                        take = 1'b1;                  // follow
                    end else begin
                        state_d = ST_PEND;            // start
                        cnt_d   = CNT_W'(1);
                    end
                end
            end
            ST_PEND: begin
                if (!mismatch) begin
                    state_d = ST_IDLE;                // drop
                    cnt_d   = '0;
                end else if (cnt_q >= sup_len) begin
                    state_d = ST_IDLE;                // accept
                    cnt_d   = '0;
                    take    = 1'b1;
                end else begin
                    cnt_d = CNT_W'(cnt_q + CNT_W'(1));
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= IDLE_LVL;
        end else if (take) begin
            level_q <= sync_in;
        end
    end

    // R5/R7: output only moves to a synchronised level that differed from it
    a_r7_move_to_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> (level_q == $past(sync_in)));

    // R6: a matching level clears the qualification count
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!mismatch) |=> (cnt_q == '0));

    // R2/R3: zero suppression follows the synchroniser one cycle later
    a_r2_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_len == '0 && mismatch) |=> (level_q == $past(sync_in)));

    // R5: count stays within the largest suppression length
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= CNT_W'(MAX_SUP)));

    // R1: idle state carries no pending count
    a_r1_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cnt_q == '0));

endmodule

// File: rtl/glitch_filter.sv
module glitch_filter #(
    parameter int   CODE_W   = 3,
    parameter int   STAGES   = 3,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] filt_sel,
    input  logic              raw_in,
    output logic              filt_out
);

    localparam int MAX_SUP = (1 << CODE_W) - 2;
    localparam int CNT_W   = $clog2(MAX_SUP + 1);

    logic             deep;
    logic [CNT_W-1:0] sup_len;
    logic             sync_lvl;

    gf_decode #(.CODE_W(CODE_W)) u_dec (
        .code    (filt_sel),
        .deep    (deep),
        .sup_len (sup_len)
    );

    gf_sync #(.STAGES(STAGES), .IDLE_LVL(IDLE_LVL)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .deep     (deep),
        .raw_in   (raw_in),
        .sync_out (sync_lvl)
    );

    gf_suppress #(.CNT_W(CNT_W), .MAX_SUP(MAX_SUP), .IDLE_LVL(IDLE_LVL)) u_sup (
        .clk       (clk),
        .rst_n     (rst_n),
        .sup_len   (sup_len),
        .sync_in   (sync_lvl),
        .level_out (filt_out)
    );

    // R1: output sits at the idle level right after reset release
    a_r1_reset_idle: assert property (@(posedge clk)
        ($rose(rst_n)) |-> (filt_out == IDLE_LVL));

endmodule

// File: tb/glitch_filter_test.sv
module glitch_filter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] filt_sel = 3'b000;
    logic       raw_in = 1'b1;
    logic       filt_out;
    int         total = 0;
    int         bad = 0;

    always #4 clk = ~clk;

    glitch_filter uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .filt_sel (filt_sel),
        .raw_in   (raw_in),
        .filt_out (filt_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle(input logic lvl);
        @(negedge clk);
        raw_in = lvl;
        repeat (16) @(negedge clk);
    endtask

    function automatic int lat_of(input logic [2:0] c);
        return (c == 3'd0) ? 3 : int'(c) + 3;
    endfunction

    function automatic int sup_of(input logic [2:0] c);
        return (c < 3'd2) ? 0 : int'(c) - 1;
    endfunction

    // R1: reset state
    task automatic t_reset;
        rst_n  = 1'b0;
        raw_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(filt_out == 1'b1, "R1 during reset", filt_out, 1);
        raw_in = 1'b1;
        rst_n  = 1'b1;
        repeat (2) @(negedge clk);
        chk(filt_out == 1'b1, "R1 after reset", filt_out, 1);
    endtask

    // R2/R3/R4: edge on which a lasting change appears
    task automatic t_latency(input logic [2:0] c, input string req);
        logic old;
        filt_sel = c;
        settle(~filt_out);
        old = filt_out;
        raw_in = ~old;
        repeat (lat_of(c) - 1) @(posedge clk);
        @(negedge clk);
        chk(filt_out == old, {req, " early"}, filt_out, old);
        @(posedge clk);
        @(negedge clk);
        chk(filt_out == ~old, {req, " on time"}, filt_out, ~old);
    endtask

    // R5/R8: pulse of width w on baseline base
    task automatic t_pulse(input logic [2:0] c, input int w, input logic base, input string req);
        int n;
        int exp;
        filt_sel = c;
        settle(base);
        raw_in = ~base;
        repeat (w) @(negedge clk);
        raw_in = base;
        n = 0;
        repeat (25) begin
            @(negedge clk);
            if (filt_out != base) n++;
        end
        exp = (w >= sup_of(c) + 1) ? w : 0;
        chk(n == exp, req, n, exp);
    endtask

    // R6: broken runs never qualify
    task automatic t_restart;
        int n;
        filt_sel = 3'd4;
        settle(1'b1);
        n = 0;
        fork
            begin
                raw_in = 1'b0; repeat (2) @(negedge clk);
                raw_in = 1'b1; repeat (1) @(negedge clk);
                raw_in = 1'b0; repeat (2) @(negedge clk);
                raw_in = 1'b1; repeat (1) @(negedge clk);
                raw_in = 1'b0; repeat (3) @(negedge clk);
                raw_in = 1'b1;
            end
            begin
                repeat (30) begin
                    @(negedge clk);
                    if (filt_out != 1'b1) n++;
                end
            end
        join
        chk(n == 0, "R6 restart on return", n, 0);
    endtask

    // R7: setting changes cause no spurious edges
    task automatic t_setting;
        int edges;
        logic prev;
        settle(1'b1);
        edges = 0;
        prev  = filt_out;
        for (int k = 0; k < 8; k++) begin
            filt_sel = 3'(k);
            repeat (3) begin
                @(negedge clk);
                if (filt_out != prev) edges++;
                prev = filt_out;
            end
        end
        chk(edges == 0, "R7 steady input", edges, 0);
        filt_sel = 3'd7;
        raw_in   = 1'b0;
        edges    = 0;
        prev     = filt_out;
        repeat (5) begin
            @(negedge clk);
            if (filt_out != prev) edges++;
            prev = filt_out;
        end
        filt_sel = 3'd2;
        repeat (3) begin
            @(negedge clk);
            if (filt_out != prev) edges++;
            prev = filt_out;
        end
        filt_sel = 3'd0;
        repeat (20) begin
            @(negedge clk);
            if (filt_out != prev) edges++;
            prev = filt_out;
        end
        chk(edges == 1, "R7 change while timing", edges, 1);
        chk(filt_out == 1'b0, "R7 final level", filt_out, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_latency(3'd0, "R2");
        t_latency(3'd0, "R2");
        t_latency(3'd1, "R3");
        t_latency(3'd2, "R4");
        t_latency(3'd5, "R4");
        t_latency(3'd7, "R4");
        t_pulse(3'd0, 1, 1'b1, "R2 one-clock pulse kept");
        t_pulse(3'd2, 1, 1'b1, "R5 N=1 w=1 dropped");
        t_pulse(3'd2, 2, 1'b1, "R5 N=1 w=2 kept");
        t_pulse(3'd4, 3, 1'b1, "R5 N=3 w=3 dropped");
        t_pulse(3'd4, 4, 1'b1, "R5 N=3 w=4 kept");
        t_pulse(3'd7, 6, 1'b1, "R5 N=6 w=6 dropped");
        t_pulse(3'd7, 7, 1'b1, "R5 N=6 w=7 kept");
        t_pulse(3'd4, 3, 1'b0, "R8 high pulse dropped");
        t_pulse(3'd4, 5, 1'b0, "R8 high pulse kept");
        t_restart();
        t_setting();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule